// File: doc/BRIEF.md
# Audio Converter Startup and Clock-Mode Sequencer

This block brings the digital side of a serial audio converter out of power-down. Every input is sampled on a fast free-running system clock `clk`. First it waits until the converter master clock (`mclkIn`) shows steady activity. It then reads a strap level on the data pin once to choose its role.

With the strap low (a pull-down is fitted), the block is the clock master. It produces the frame clock on `lrckOut` by dividing the master clock by 256. With the strap high, the block is a slave. It watches the incoming frame clock and counts master-clock edges over one frame to classify the clock ratio.

Once the clocking is settled, the block turns on the voltage reference. It keeps the serial data pin parked at a fixed level, low for master and high for slave, for a programmable number of frames, so the downstream filters can settle. After that it raises `ready` and releases the data pin to normal traffic.

The `mclkIn` and `lrckIn` inputs must run at under half the rate of `clk`. The settling length defaults to 11,265 frames, which is about 235 ms at a 48 kHz frame rate. All real-time figures scale with the frame rate.

Top module: `adc_startup_seq`

## Requirements
- R1: After reset the outputs are `refEn`=0, `ready`=0, `dataHold`=1, `ratioCode`=0, `ratioErr`=0, `lrckOut`=0 and `masterMode`=0.
- R2: The block stays in power-down until `PRESENT_EDGES` (default 4) master-clock rising edges arrive, each no more than `WDOG_LIMIT` (default 64) `clk` cycles after the one before. A slower clock never leaves power-down.
- R3: The strap is read once, when the master clock is first found. Low gives master (`masterMode`=1) and high gives slave (`masterMode`=0). Later strap changes have no effect until the next reset.
- R4: In master mode, `refEn` rises and the frame divider starts at the 127th master-clock rising edge after the mode decision. `lrckOut` is then the master clock divided by 256, high for 128 edges and low for 128 edges.
- R5: In master mode `ratioCode` reads 1, which encodes 256.
- R6: In slave mode the block counts master-clock rising edges between two consecutive `lrckIn` rising edges. A count within ±2 of 256, 384 or 512 sets `ratioCode` to 1, 2 or 3 respectively and raises `refEn`.
- R7: A count outside every tolerance window sets `ratioErr`=1, keeps `refEn` low, and repeats the measurement on the next frame. A later valid measurement clears `ratioErr`.
- R8: In slave mode, if no `lrckIn` rising edge arrives within 1024 master-clock edges, the block keeps waiting. It does not raise `refEn` or `ratioErr`.
- R9: From the rise of `refEn` until `ready` rises, `dataHold` stays 1 for `SETTLE_FRAMES` frames. `holdLevel` is 0 in master mode and 1 in slave mode.
- R10: `ready` rises one `clk` cycle after the settle count reaches `SETTLE_FRAMES`. From then on `ready` and `refEn` stay high and `dataHold` stays 0 until reset.
- R11: In slave mode `lrckOut` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock; every other input is sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| mclkIn | input | 1 | Converter master clock |
| lrckIn | input | 1 | Frame clock from the external master (slave mode) |
| strapIn | input | 1 | Sensed level of the data-pin strap |
| lrckOut | output | 1 | Generated frame clock (master mode) |
| masterMode | output | 1 | 1 when the strap selected master mode |
| ratioCode | output | 2 | Clock ratio: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| ratioErr | output | 1 | Last slave measurement was outside every window |
| refEn | output | 1 | Voltage reference enable |
| dataHold | output | 1 | 1 while the data pin must be parked at `holdLevel` |
| holdLevel | output | 1 | Level at which the data pin is parked |
| ready | output | 1 | Settling finished; normal data allowed |

## Verification
The in-RTL assertions check, on every cycle, several relationships between the controller and the datapath. A latched `ready` never falls, and it always comes with `refEn`. `refEn` never appears without a detected master clock or together with `ratioErr`. The mode never changes once it is chosen. The generated frame clock only moves right after a master-clock edge and stays quiet in slave mode. Only the bench scenarios can show the properties that depend on timing or measurement: the 127-edge start delay, the 256-cycle frame half-period, the classification of each legal ratio, the rejection and retry of an illegal one, the wait while the frame clock is absent, and the exact count of settling frames before release.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    RATIO_NONE = 2'd0,
    RATIO_256  = 2'd1,
    RATIO_384  = 2'd2,
    RATIO_512  = 2'd3
  } ratio_e;

  typedef enum logic [2:0] {
    ST_PWRDN,
    ST_MINIT,
    ST_SWAIT,
    ST_SMEAS,
    ST_SETTLE,
    ST_RUN
  } seqState_e;

  // strobes from the sequencer control into the datapath
  typedef struct packed {
    logic clrCnt;
    logic latchMode;
    logic startLrck;
    logic latchRatio;
    logic flagErr;
    logic clrSettle;
    logic countFrames;
  } seqStrobe_t;

endpackage

// File: rtl/adc_startup_dp.sv
module adc_startup_dp
  import adcseq_pkg::*;
#(
  parameter int SETTLE_FRAMES = 11265,
  parameter int WDOG_LIMIT    = 64,
  parameter int PRESENT_EDGES = 4,
  parameter int LRCK_TIMEOUT  = 1024,
  parameter int TOL           = 2,
  localparam int CNT_W = $clog2(LRCK_TIMEOUT) + 1,
  localparam int SET_W = $clog2(SETTLE_FRAMES + 1),
  localparam int WD_W  = $clog2(WDOG_LIMIT + 1),
  localparam int PE_W  = $clog2(PRESENT_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mclkIn,
  input  logic             lrckIn,
  input  logic             strapIn,
  input  seqStrobe_t       stb,
  output logic             mclkPresent,
  output logic             mclkRise,
  output logic             lrckRise,
  output logic [CNT_W-1:0] mclkCnt,
  output logic             strapLvl,
  output logic             ratioOk,
  output logic             settleDone,
  output logic             modeMaster,
  output ratio_e           ratioQ,
  output logic             ratioErr,
  output logic             lrckOut
);

  localparam int DIV_W = 8;  // master divide by 256

  // three-stage capture: two for metastability, one for edge detect
  logic [2:0] rawIn, syncA, syncB, syncC;
  assign rawIn = {strapIn, lrckIn, mclkIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign mclkRise = syncB[0] & ~syncC[0];
  assign lrckRise = syncB[1] & ~syncC[1];
  assign strapLvl = syncB[2];

  // master clock activity watchdog
  logic [WD_W-1:0] gapCnt;
  logic [PE_W-1:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt      <= '0;
      edgeCnt     <= '0;
      mclkPresent <= 1'b0;
    end else begin
      if (mclkRise) begin
        gapCnt <= '0;
        if (edgeCnt != PE_W'(PRESENT_EDGES)) edgeCnt <= edgeCnt + 1'b1;
      end else if (gapCnt == WD_W'(WDOG_LIMIT)) begin
        if (!mclkPresent) edgeCnt <= '0;
      end else begin
        gapCnt <= gapCnt + 1'b1;
      end
      if (edgeCnt == PE_W'(PRESENT_EDGES)) mclkPresent <= 1'b1;
    end
  end

  // master clock edge counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mclkCnt <= '0;
    else if (stb.clrCnt) mclkCnt <= '0;
    else if (mclkRise && !(&mclkCnt)) mclkCnt <= mclkCnt + 1'b1;
  end

  // ratio classification against the three legal windows
  logic [2:0] hit;
  for (genvar g = 0; g < 3; g++) begin : g_window
    localparam int TARGET = 256 + 128 * g;
    assign hit[g] = ({1'b0, mclkCnt} + (CNT_W+1)'(TOL) >= (CNT_W+1)'(TARGET)) &&
                    ({1'b0, mclkCnt} <= (CNT_W+1)'(TARGET + TOL));
  end

  ratio_e ratioNow;
  always_comb begin
    if (hit[2])      ratioNow = RATIO_512;
    else if (hit[1]) ratioNow = RATIO_384;
    else if (hit[0]) ratioNow = RATIO_256;
    else             ratioNow = RATIO_NONE;
  end
  assign ratioOk = |hit;

  // mode latch, once per reset
  logic modeDone;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeMaster <= 1'b0;
      modeDone   <= 1'b0;
    end else if (stb.latchMode && !modeDone) begin
      modeMaster <= ~strapLvl;
      modeDone   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioQ   <= RATIO_NONE;
      ratioErr <= 1'b0;
    end else if (stb.latchRatio) begin
      ratioQ   <= modeMaster ? RATIO_256 : ratioNow;
      ratioErr <= 1'b0;
    end else if (stb.flagErr) begin
      ratioErr <= 1'b1;
    end
  end

  // master frame divider
  logic             lrckRun;
  logic [DIV_W-1:0] divCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrckRun <= 1'b0;
      divCnt  <= '0;
    end else begin
      if (stb.startLrck) lrckRun <= 1'b1;
      if (lrckRun && mclkRise) divCnt <= divCnt + 1'b1;
    end
  end
  assign lrckOut = divCnt[DIV_W-1];

  // settling frame counter
  logic             frameTick;
  logic [SET_W-1:0] settleCnt;
  assign frameTick  = modeMaster ? (lrckRun && mclkRise && (&divCnt)) : lrckRise;
  assign settleDone = (settleCnt == SET_W'(SETTLE_FRAMES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) settleCnt <= '0;
    else if (stb.clrSettle) settleCnt <= '0;
    else if (stb.countFrames && frameTick && !settleDone) settleCnt <= settleCnt + 1'b1;
  end

  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    modeDone |=> (modeDone && $stable(modeMaster)));

  a_r4_lrck_follows_mclk: assert property (@(posedge clk) disable iff (!rstN)
    (lrckOut != $past(lrckOut)) |-> $past(mclkRise));

  a_r11_slave_lrck_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (modeDone && !modeMaster) |-> !lrckOut);

endmodule

// File: rtl/adc_startup_ctrl.sv
module adc_startup_ctrl
  import adcseq_pkg::*;
#(
  parameter int LRCK_TIMEOUT      = 1024,
  parameter int MASTER_INIT_EDGES = 127,
  localparam int CNT_W = $clog2(LRCK_TIMEOUT) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mclkPresent,
  input  logic             mclkRise,
  input  logic             lrckRise,
  input  logic [CNT_W-1:0] mclkCnt,
  input  logic             strapLvl,
  input  logic             ratioOk,
  input  logic             settleDone,
  output seqStrobe_t       stb,
  output logic             refEn,
  output logic             ready
);

  seqState_e st, nxt;
  logic      lrckLost;
  assign lrckLost = (mclkCnt >= CNT_W'(LRCK_TIMEOUT));

  always_comb begin
    stb = '0;
    nxt = st;
    case (st)
      ST_PWRDN: if (mclkPresent) begin
        stb.latchMode = 1'b1;
        stb.clrCnt    = 1'b1;
        nxt = strapLvl ? ST_SWAIT : ST_MINIT;
      end
      ST_MINIT: if (mclkRise && mclkCnt == CNT_W'(MASTER_INIT_EDGES - 1)) begin
        stb.startLrck  = 1'b1;
        stb.latchRatio = 1'b1;
        stb.clrSettle  = 1'b1;
        nxt = ST_SETTLE;
      end
      ST_SWAIT: begin
        if (lrckRise) begin
          stb.clrCnt = 1'b1;
          nxt = ST_SMEAS;
        end else if (lrckLost) begin
          stb.clrCnt = 1'b1;
        end
      end
      ST_SMEAS: begin
        if (lrckRise) begin
          if (ratioOk) begin
            stb.latchRatio = 1'b1;
            stb.clrSettle  = 1'b1;
            nxt = ST_SETTLE;
          end else begin
            stb.flagErr = 1'b1;
            stb.clrCnt  = 1'b1;
          end
        end else if (lrckLost) begin
          stb.clrCnt = 1'b1;
          nxt = ST_SWAIT;
        end
      end
      ST_SETTLE: begin
        stb.countFrames = 1'b1;
        if (settleDone) nxt = ST_RUN;
      end
      ST_RUN:  nxt = ST_RUN;
      default: nxt = ST_PWRDN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_PWRDN;
      refEn <= 1'b0;
      ready <= 1'b0;
    end else begin
      st <= nxt;
      if (stb.latchRatio) refEn <= 1'b1;
      if (st == ST_SETTLE && settleDone) ready <= 1'b1;
    end
  end

  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  a_r9_ready_needs_ref: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> refEn);

  a_r2_ref_needs_clock: assert property (@(posedge clk) disable iff (!rstN)
    refEn |-> mclkPresent);

endmodule

// File: rtl/adc_startup_seq.sv
module adc_startup_seq
  import adcseq_pkg::*;
#(
  parameter int SETTLE_FRAMES     = 11265,
  parameter int WDOG_LIMIT        = 64,
  parameter int PRESENT_EDGES     = 4,
  parameter int LRCK_TIMEOUT      = 1024,
  parameter int RATIO_TOL         = 2,
  parameter int MASTER_INIT_EDGES = 127
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mclkIn,
  input  logic       lrckIn,
  input  logic       strapIn,
  output logic       lrckOut,
  output logic       masterMode,
  output logic [1:0] ratioCode,
  output logic       ratioErr,
  output logic       refEn,
  output logic       dataHold,
  output logic       holdLevel,
  output logic       ready
);

  localparam int CNT_W = $clog2(LRCK_TIMEOUT) + 1;

  seqStrobe_t       stb;
  logic             mclkPresent, mclkRise, lrckRise, strapLvl, ratioOk, settleDone;
  logic [CNT_W-1:0] mclkCnt;
  ratio_e           ratioQ;

  adc_startup_dp #(
    .SETTLE_FRAMES(SETTLE_FRAMES),
    .WDOG_LIMIT   (WDOG_LIMIT),
    .PRESENT_EDGES(PRESENT_EDGES),
    .LRCK_TIMEOUT (LRCK_TIMEOUT),
    .TOL          (RATIO_TOL)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .mclkIn     (mclkIn),
    .lrckIn     (lrckIn),
    .strapIn    (strapIn),
    .stb        (stb),
    .mclkPresent(mclkPresent),
    .mclkRise   (mclkRise),
    .lrckRise   (lrckRise),
    .mclkCnt    (mclkCnt),
    .strapLvl   (strapLvl),
    .ratioOk    (ratioOk),
    .settleDone (settleDone),
    .modeMaster (masterMode),
    .ratioQ     (ratioQ),
    .ratioErr   (ratioErr),
    .lrckOut    (lrckOut)
  );

  adc_startup_ctrl #(
    .LRCK_TIMEOUT     (LRCK_TIMEOUT),
    .MASTER_INIT_EDGES(MASTER_INIT_EDGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mclkPresent(mclkPresent),
    .mclkRise   (mclkRise),
    .lrckRise   (lrckRise),
    .mclkCnt    (mclkCnt),
    .strapLvl   (strapLvl),
    .ratioOk    (ratioOk),
    .settleDone (settleDone),
    .stb        (stb),
    .refEn      (refEn),
    .ready      (ready)
  );

  assign ratioCode = ratioQ;
  assign holdLevel = ~masterMode;
  assign dataHold  = ~ready;

  a_r7_err_blocks_ref: assert property (@(posedge clk) disable iff (!rstN)
    ratioErr |-> !refEn);

endmodule

// File: tb/adc_startup_seq_bench.sv
module adc_startup_seq_bench;

  localparam int SETTLE = 3;

  logic       clk = 1'b0, rstN = 1'b0;
  logic       mclkIn = 1'b0, lrckIn = 1'b0, strapIn = 1'b0;
  logic       lrckOut, masterMode, ratioErr, refEn, dataHold, holdLevel, ready;
  logic [1:0] ratioCode;

  adc_startup_seq #(.SETTLE_FRAMES(SETTLE)) u_adc_startup_seq (
    .clk(clk), .rstN(rstN), .mclkIn(mclkIn), .lrckIn(lrckIn), .strapIn(strapIn),
    .lrckOut(lrckOut), .masterMode(masterMode), .ratioCode(ratioCode),
    .ratioErr(ratioErr), .refEn(refEn), .dataHold(dataHold),
    .holdLevel(holdLevel), .ready(ready)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // clock and frame stimulus, driven 2 ns after the rising edge
  bit mclkOn = 0, lrckOn = 0;
  int mclkHalf = 1, lrckRatio = 256, ph = 0, lc = 0, rawLrckRises = 0;

  initial forever begin
    @(posedge clk);
    #2;
    if (mclkOn) begin
      if (ph >= mclkHalf - 1) begin
        ph = 0;
        mclkIn = ~mclkIn;
        if (mclkIn && lrckOn) begin
          lc++;
          if (lc >= lrckRatio / 2) begin
            lc = 0;
            lrckIn = ~lrckIn;
            if (lrckIn) rawLrckRises++;
          end
        end
      end else ph++;
    end
  end

  // scoreboard
  typedef struct {
    bit master;
    int ratio;
    bit hold;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  task automatic expectStart(input bit master, input int ratio, input bit hold);
    exp_t e;
    e.master = master; e.ratio = ratio; e.hold = hold;
    q.push_back(e);
  endtask

  bit   haveCur = 0, holdBroke = 0, widthChecked = 0, slaveLrckHigh = 0;
  int   cyc = 0, modeRiseCyc = 0, framesSeen = 0, rawBase = 0, lrckRiseCyc = 0;
  logic pRef = 0, pReady = 0, pMode = 0, pLrck = 0;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (rstN) begin
      if (masterMode && !pMode) modeRiseCyc = cyc;
      if (!masterMode && refEn && lrckOut) slaveLrckHigh = 1;
      if (lrckOut && !pLrck) lrckRiseCyc = cyc;
      if (!lrckOut && pLrck && !widthChecked) begin
        widthChecked = 1;
        chk(cyc - lrckRiseCyc == 256, "R4 lrck high width", cyc - lrckRiseCyc, 256);
      end
      if (refEn && !pRef) begin
        if (q.size() == 0) chk(0, "R6 unexpected reference enable", 1, 0);
        else begin
          cur = q.pop_front();
          chk(masterMode == cur.master, "R3 mode at start", masterMode, cur.master);
          if (cur.master) begin
            chk(ratioCode == 2'(cur.ratio), "R5 master ratio", ratioCode, cur.ratio);
            chk(cyc - modeRiseCyc >= 252 && cyc - modeRiseCyc <= 256,
                "R4 init delay", cyc - modeRiseCyc, 254);
          end else
            chk(ratioCode == 2'(cur.ratio), "R6 slave ratio", ratioCode, cur.ratio);
          chk(holdLevel == cur.hold, "R9 hold level", holdLevel, cur.hold);
          chk(dataHold == 1'b1, "R9 hold at start", dataHold, 1);
          framesSeen = 0;
          rawBase    = rawLrckRises;
          holdBroke  = 0;
          haveCur    = 1;
        end
      end
      if (haveCur && refEn && !ready) begin
        if (!dataHold) holdBroke = 1;
        if (masterMode && pLrck && !lrckOut) framesSeen++;
      end
      if (haveCur && ready && !pReady) begin
        int frames;
        frames = masterMode ? framesSeen : rawLrckRises - rawBase;
        chk(frames == SETTLE, "R9 settle frames", frames, SETTLE);
        chk(!holdBroke, "R9 hold through settle", holdBroke, 0);
        chk(dataHold == 1'b0, "R10 hold released", dataHold, 0);
        haveCur = 0;
      end
    end
    pRef = refEn; pReady = ready; pMode = masterMode; pLrck = lrckOut;
  end

  task automatic doReset();
    @(posedge clk); #2;
    rstN = 1'b0; mclkOn = 0; lrckOn = 0; lrckIn = 1'b0; lc = 0;
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
  endtask

  task automatic waitReady(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ready) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state, no clock
    doReset();
    strapIn = 1'b0;
    repeat (300) @(negedge clk);
    chk(refEn == 0, "R1 refEn", refEn, 0);
    chk(ready == 0, "R1 ready", ready, 0);
    chk(dataHold == 1, "R1 dataHold", dataHold, 1);
    chk(ratioCode == 0, "R1 ratioCode", ratioCode, 0);
    chk(ratioErr == 0, "R1 ratioErr", ratioErr, 0);
    chk(lrckOut == 0 && masterMode == 0, "R1 lrck and mode", {lrckOut, masterMode}, 0);

    // slow clock: gaps beyond the watchdog keep power-down
    mclkHalf = 80; mclkOn = 1;
    repeat (3000) @(negedge clk);
    chk(refEn == 0 && masterMode == 0, "R2 slow clock ignored", {refEn, masterMode}, 0);

    // master mode
    expectStart(1'b1, 1, 1'b0);
    @(posedge clk); #2 mclkHalf = 1;
    waitReady(20000);
    chk(ready == 1, "R10 master ready", ready, 1);
    chk(widthChecked == 1, "R4 lrck observed", widthChecked, 1);
    strapIn = 1'b1;
    repeat (800) @(negedge clk);
    chk(masterMode == 1, "R3 strap change ignored in master", masterMode, 1);
    chk(ready == 1 && refEn == 1 && dataHold == 0, "R10 stays ready", {ready, refEn, dataHold}, 6);

    // slave at 384
    doReset();
    strapIn = 1'b1; slaveLrckHigh = 0;
    lrckRatio = 384; lrckOn = 1; mclkHalf = 1; mclkOn = 1;
    expectStart(1'b0, 2, 1'b1);
    waitReady(20000);
    chk(ready == 1, "R6 slave 384 ready", ready, 1);
    strapIn = 1'b0;
    repeat (2000) @(negedge clk);
    chk(masterMode == 0, "R3 strap change ignored in slave", masterMode, 0);
    chk(ratioCode == 2, "R6 ratio held", ratioCode, 2);
    chk(slaveLrckHigh == 0, "R11 slave lrck quiet", slaveLrckHigh, 0);

    // slave at 256
    doReset();
    strapIn = 1'b1;
    lrckRatio = 256; lrckOn = 1; mclkOn = 1;
    expectStart(1'b0, 1, 1'b1);
    waitReady(20000);
    chk(ready == 1, "R6 slave 256 ready", ready, 1);

    // slave: absent frame clock, illegal ratio, then 512
    doReset();
    strapIn = 1'b1; mclkOn = 1;
    repeat (5000) @(negedge clk);
    chk(refEn == 0, "R8 no frame clock keeps ref off", refEn, 0);
    chk(ratioErr == 0, "R8 no frame clock no error", ratioErr, 0);
    lrckRatio = 300; lc = 0; lrckOn = 1;
    repeat (1600) @(negedge clk);
    chk(ratioErr == 1, "R7 illegal ratio flagged", ratioErr, 1);
    chk(refEn == 0, "R7 illegal ratio keeps ref off", refEn, 0);
    @(posedge clk); #2 lrckOn = 0; lrckIn = 1'b0; lc = 0;
    repeat (3000) @(negedge clk);
    chk(refEn == 0, "R7 still off after gap", refEn, 0);
    expectStart(1'b0, 3, 1'b1);
    @(posedge clk); #2 lrckRatio = 512; lc = 0; lrckOn = 1;
    waitReady(20000);
    chk(ready == 1, "R6 slave 512 ready", ready, 1);
    chk(ratioErr == 0, "R7 error cleared", ratioErr, 0);

    chk(q.size() == 0, "R6 all expected starts seen", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule